// File: doc/BRIEF.md
# Smart Card Early Answer Detector

This block watches a smart card's I/O line while the card is being reset and raises a sticky flag when the card begins its answer too soon. It runs on the card clock. It follows the card reset line level and counts card clocks from the latest edge of that line, so there is one count for the reset-low phase and one for the reset-high phase. From that count it decodes a detection window for each phase.

Inside a window, a start bit is accepted only when the I/O line stays low for a full qualification run of card clocks. Every clock of that run must fall inside the window, and the line must have been seen high inside the same window before it went low. An accepted start bit sets the early-answer flag, and the interrupt request follows the flag. Software clears the flag by reading status. The flag is also cleared when the interface moves to another card.

The last part of each window is blind: start bits that would complete there are not reported.

Top module: `early_answer_detector`

## Requirements
- R1: After interface reset (`rst_n` low at a clock edge), `ea_flag` and `irq` are 0.
- R2: With `card_rst` low, a run of 46 consecutive low samples of `card_io` that lies entirely within clocks 200..335 after the falling edge of `card_rst` sets `ea_flag`. The line must have been sampled high at least once at or after clock 200 before the run.
- R3: With `card_rst` high, a run of 46 consecutive low samples that lies entirely within clocks 0..335 after the rising edge of `card_rst` sets `ea_flag`. The line must have been sampled high at least once inside that window before the run.
- R4: A low run shorter than 46 clocks never sets the flag. For a qualifying run, `ea_flag` reads 1 immediately after the clock edge that samples its 46th low, and not before.
- R5: The blind zone is clocks 336..368 of either phase. A run whose 46th low would fall at clock 336 or later is not reported, and nothing is reported outside the windows.
- R6: A low level already present on `card_io` when a window opens is not counted. Detection needs a high sample inside the window first.
- R7: `irq` equals `ea_flag` at all times.
- R8: A `status_rd` pulse clears `ea_flag` one clock later. If a detection completes at the same edge, the flag is set instead.
- R9: A `card_switch` pulse clears `ea_flag` one clock later, overriding a detection at the same edge. It also abandons a qualification run that is in progress.
- R10: The card clock count restarts at 0 on every edge of `card_rst` and saturates at 368, so no window opens again later in the same phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Synchronous active-low interface reset |
| card_rst | input | 1 | Level of the card reset line |
| card_io | input | 1 | Card I/O line, idle high, start bit low |
| status_rd | input | 1 | Status read strobe, one clock wide, clears the flag |
| card_switch | input | 1 | One-clock pulse when the interface selects another card |
| ea_flag | output | 1 | Sticky early-answer flag |
| irq | output | 1 | Interrupt request, follows the flag |

## Verification
The embedded assertions check every cycle for the following:
- the clock count restarts on each reset-line edge and never exceeds its saturation value;
- no detection occurs in the blind zone;
- a detection sets the flag, and the flag rises only on a detection;
- status reads and card switches clear the flag with the documented priority.

The window boundaries cannot be judged from any single cycle. These include the exact first and last clocks of each window, the rule that a low level present at window opening does not count, and the requirement that the count does not wrap and reopen a window. Only the bench sweeps show these, by moving a 46-clock low run across both phases and comparing the flag on every clock with arithmetic on the window limits.

// File: rtl/ead_pkg.sv
// Shared types and defaults for the early answer detector.
package ead_pkg;
    // Phase of the card reset line as seen by the detector.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    localparam int unsigned DEF_LOW_OPEN = 200;  // first watched clock while reset is low
    localparam int unsigned DEF_SPAN     = 368;  // nominal window end, counter saturation
    localparam int unsigned DEF_BLIND    = 32;   // unwatched clocks at the end of a window
    localparam int unsigned DEF_QUAL     = 46;   // low clocks needed to accept a start bit
endpackage

// File: rtl/ead_phase_counter.sv
// Tracks the card reset line level and counts card clocks since its last edge.
// Assumes card_rst is already synchronous to clk. The count saturates at SPAN.
module ead_phase_counter
    import ead_pkg::*;
#(
    parameter int unsigned SPAN  = DEF_SPAN,
    parameter int unsigned CNT_W = $clog2(SPAN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             card_rst,
    output phase_e           phase,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(SPAN);

    logic             lvl_q;
    logic [CNT_W-1:0] cnt_q;

    // Restart the count on any reset-line edge, otherwise count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            cnt_q <= '0;
        end else if (card_rst != lvl_q) begin
            lvl_q <= card_rst;
            cnt_q <= '0;
        end else if (cnt_q != SAT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign phase = lvl_q ? PH_HIGH : PH_LOW;
    assign cnt   = cnt_q;

    // R10
    restart_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (card_rst != lvl_q) |=> (cnt_q == '0));
    // R10
    count_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SAT);
endmodule

// File: rtl/ead_window_decode.sv
// Decodes whether the current card clock lies in an active detection window.
// Reset-low window: OPEN..CLOSE-1. Reset-high window: 0..CLOSE-1.
module ead_window_decode
    import ead_pkg::*;
#(
    parameter int unsigned OPEN  = DEF_LOW_OPEN,
    parameter int unsigned CLOSE = DEF_SPAN - DEF_BLIND,
    parameter int unsigned CNT_W = 9
) (
    input  phase_e           phase,
    input  logic [CNT_W-1:0] cnt,
    output logic             win
);
    localparam logic [CNT_W-1:0] OPEN_C  = CNT_W'(OPEN);
    localparam logic [CNT_W-1:0] CLOSE_C = CNT_W'(CLOSE);

    // Select the lower bound by phase and apply the common upper bound.
    always_comb begin
        if (phase == PH_HIGH) win = (cnt < CLOSE_C);
        else                  win = (cnt >= OPEN_C) && (cnt < CLOSE_C);
    end
endmodule

// File: rtl/ead_start_qualifier.sv
// Accepts a start bit when card_io is low for QUAL consecutive clocks inside
// an active window, after being seen high in that window. Emits a one-clock
// detect pulse on the clock that samples the last low of the run.
module ead_start_qualifier
    import ead_pkg::*;
#(
    parameter int unsigned QUAL  = DEF_QUAL,
    parameter int unsigned RUN_W = $clog2(QUAL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic win,
    input  logic card_io,
    input  logic abort,
    output logic detect
);
    localparam logic [RUN_W-1:0] LAST = RUN_W'(QUAL - 1);
    localparam logic [RUN_W-1:0] FULL = RUN_W'(QUAL);

    logic             armed_q;
    logic [RUN_W-1:0] run_q;
    logic             low_ok;

    assign low_ok = win && !card_io && armed_q;
    assign detect = low_ok && (run_q == LAST) && !abort;

    // Arm after a high sample inside the window; disarm outside it or on abort.
    always_ff @(posedge clk) begin
        if (!rst_n || abort || !win) armed_q <= 1'b0;
        else if (card_io)            armed_q <= 1'b1;
    end

    // Count consecutive armed low samples, saturating so one run fires once.
    always_ff @(posedge clk) begin
        if (!rst_n || abort || !low_ok) run_q <= '0;
        else if (run_q != FULL)         run_q <= run_q + 1'b1;
    end

    // R4
    run_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= FULL);
    // R9
    abort_drops_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (run_q == '0));
endmodule

// File: rtl/ead_flag_reg.sv
// Sticky early-answer flag. Priority: card switch clears, then detection
// sets, then status read clears.
module ead_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic detect,
    input  logic status_rd,
    input  logic card_switch,
    output logic flag
);
    logic flag_q;

    // Update the flag with the clear/set priority above.
    always_ff @(posedge clk) begin
        if (!rst_n)           flag_q <= 1'b0;
        else if (card_switch) flag_q <= 1'b0;
        else if (detect)      flag_q <= 1'b1;
        else if (status_rd)   flag_q <= 1'b0;
    end

    assign flag = flag_q;

    // R8
    detect_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (detect && !card_switch) |=> flag_q);
    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !detect) |=> !flag_q);
    // R9
    switch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_switch |=> !flag_q);
    // R4
    rise_needs_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(detect));
endmodule

// File: rtl/early_answer_detector.sv
// Early answer detector top. Runs on the card clock. Counts clocks per reset
// phase, decodes the windows, qualifies start bits and holds a sticky flag
// that drives the interrupt request. All inputs are assumed synchronous.
module early_answer_detector
    import ead_pkg::*;
#(
    parameter int unsigned LOW_OPEN = DEF_LOW_OPEN,
    parameter int unsigned SPAN     = DEF_SPAN,
    parameter int unsigned BLIND    = DEF_BLIND,
    parameter int unsigned QUAL     = DEF_QUAL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_rst,
    input  logic card_io,
    input  logic status_rd,
    input  logic card_switch,
    output logic ea_flag,
    output logic irq
);
    localparam int unsigned CLOSE = SPAN - BLIND;
    localparam int unsigned CNT_W = $clog2(SPAN + 1);
    localparam logic [CNT_W-1:0] CLOSE_C = CNT_W'(CLOSE);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             win;
    logic             detect;

    ead_phase_counter #(.SPAN(SPAN), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .phase(phase), .cnt(cnt)
    );

    ead_window_decode #(.OPEN(LOW_OPEN), .CLOSE(CLOSE), .CNT_W(CNT_W)) u_win (
        .phase(phase), .cnt(cnt), .win(win)
    );

    ead_start_qualifier #(.QUAL(QUAL)) u_qual (
        .clk(clk), .rst_n(rst_n), .win(win), .card_io(card_io),
        .abort(card_switch), .detect(detect)
    );

    ead_flag_reg u_flag (
        .clk(clk), .rst_n(rst_n), .detect(detect), .status_rd(status_rd),
        .card_switch(card_switch), .flag(ea_flag)
    );

    // The interrupt request follows the flag directly.
    assign irq = ea_flag;

    // R5
    no_blind_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= CLOSE_C) |-> !detect);
    // R6
    detect_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        detect |-> $past(win));
endmodule

// File: tb/early_answer_detector_tb.sv
`timescale 1ns/1ps
module early_answer_detector_tb;
    localparam int LOW_OPEN = 200;
    localparam int CLOSE    = 336;
    localparam int QUAL     = 46;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic card_rst = 1'b0;
    logic card_io = 1'b1;
    logic status_rd = 1'b0;
    logic card_switch = 1'b0;
    logic ea_flag;
    logic irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    early_answer_detector u_dut (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .card_io(card_io),
        .status_rd(status_rd), .card_switch(card_switch),
        .ea_flag(ea_flag), .irq(irq)
    );

    task automatic check1(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // One reset-phase scenario: a low run of len clocks starting at clock s of
    // the phase; optional status read and card switch at given clocks.
    task automatic run_case(input string tag, input bit hi, input int s, input int len,
                            input int rd_at, input int sw_at, input int ncyc);
        int  ws;
        bit  det;
        bit  exp_f;
        int  bad_j;
        logic got_f;
        logic got_i;
        ws  = hi ? 0 : LOW_OPEN;
        det = (len >= QUAL) && (s >= ws + 1) && (s + QUAL - 1 <= CLOSE - 1);
        if (sw_at >= s && sw_at <= s + QUAL - 1) det = 1'b0;
        // Preparation: opposite phase with idle line, clear any old flag.
        @(negedge clk);
        card_rst = !hi; card_io = 1'b1; status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        repeat (3) @(negedge clk);
        card_rst = hi;
        @(posedge clk);
        exp_f = 1'b0;
        bad_j = -1;
        got_f = 1'b0;
        got_i = 1'b0;
        for (int j = 0; j < ncyc; j++) begin
            @(negedge clk);
            if (bad_j < 0 && (ea_flag !== exp_f || irq !== exp_f)) begin
                bad_j = j; got_f = ea_flag; got_i = irq;
            end
            card_io     = (j >= s && j < s + len) ? 1'b0 : 1'b1;
            status_rd   = (j == rd_at);
            card_switch = (j == sw_at);
            @(posedge clk);
            if (j == sw_at)                      exp_f = 1'b0;
            else if (det && j == s + QUAL - 1)   exp_f = 1'b1;
            else if (j == rd_at)                 exp_f = 1'b0;
        end
        @(negedge clk);
        if (bad_j < 0 && (ea_flag !== exp_f || irq !== exp_f)) begin
            bad_j = ncyc; got_f = ea_flag; got_i = irq;
        end
        status_rd = 1'b0; card_switch = 1'b0; card_io = 1'b1;
        checks++;
        if (bad_j >= 0) begin
            failures++;
            $display("FAIL %s: s=%0d len=%0d clock %0d flag/irq got %b/%b expected %b",
                     tag, s, len, bad_j, got_f, got_i, exp_f);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check1("R1 flag after reset", ea_flag, 1'b0);
        check1("R1 irq after reset", irq, 1'b0);
        rst_n = 1'b1;

        // R2 sweep of the reset-low phase
        for (int s = LOW_OPEN - 12; s <= 300; s += 7)
            run_case("R2 low sweep", 1'b0, s, QUAL, -1, -1, 400);
        // R3 sweep of the reset-high phase
        for (int s = 0; s <= 300; s += 7)
            run_case("R3 high sweep", 1'b1, s, QUAL, -1, -1, 400);

        // R6 low at window opening, first allowed start
        run_case("R6 low at open (low phase)", 1'b0, LOW_OPEN, QUAL, -1, -1, 400);
        run_case("R6 low at open (high phase)", 1'b1, 0, QUAL, -1, -1, 400);
        run_case("R6 low across open", 1'b0, 190, 100, -1, -1, 400);
        run_case("R2 first start after high", 1'b0, LOW_OPEN + 1, QUAL, -1, -1, 400);
        run_case("R3 first start after high", 1'b1, 1, QUAL, -1, -1, 400);

        // R5 blind zone boundary
        run_case("R5 run ends at 335 (low)", 1'b0, 290, QUAL, -1, -1, 400);
        run_case("R5 run ends at 336 (low)", 1'b0, 291, QUAL, -1, -1, 400);
        run_case("R5 run ends at 336 (high)", 1'b1, 291, QUAL, -1, -1, 400);
        run_case("R5 run in blind zone", 1'b1, 340, QUAL, -1, -1, 400);

        // R4 run length
        run_case("R4 short run low", 1'b0, 250, QUAL - 1, -1, -1, 400);
        run_case("R4 short run high", 1'b1, 100, QUAL - 1, -1, -1, 400);
        run_case("R4 long run", 1'b0, 250, 200, -1, -1, 400);
        run_case("R7 irq follows flag", 1'b1, 20, QUAL, -1, -1, 200);

        // R10 saturation: no window reopens late in the phase
        run_case("R10 no wrap high", 1'b1, 520, QUAL, -1, -1, 600);
        run_case("R10 no wrap low", 1'b0, 720, QUAL, -1, -1, 800);

        // R8 status read
        run_case("R8 read after set", 1'b1, 50, QUAL, 150, -1, 250);
        run_case("R8 read same edge as set", 1'b1, 50, QUAL, 50 + QUAL - 1, -1, 250);
        run_case("R8 read one edge after set", 1'b0, 220, QUAL, 220 + QUAL, -1, 400);

        // R9 card switch
        run_case("R9 switch mid run", 1'b1, 50, QUAL, -1, 70, 250);
        run_case("R9 switch same edge as set", 1'b1, 50, QUAL, -1, 50 + QUAL - 1, 250);
        run_case("R9 switch after set", 1'b0, 210, QUAL, -1, 300, 400);

        // R1 interface reset clears a set flag
        run_case("R1 set before reset", 1'b1, 30, QUAL, -1, -1, 120);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check1("R1 flag cleared by reset", ea_flag, 1'b0);
        check1("R1 irq cleared by reset", irq, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule